// File: doc/BRIEF.md
# Prescaled Free-Running Counter with Overflow Flag

This block keeps a 16-bit up-counter that advances on ticks from a selectable clock divider. When the counter rolls over from its all-ones value to zero, a sticky overflow flag is set. When the overflow interrupt is enabled, that flag drives an interrupt request. Neighbouring timer functions get the live count on a dedicated output bus.

Software reaches the block through a byte-wide register strobe with four addresses. The two count bytes are read-only. A control byte holds the interrupt enable and the divider select. A status byte holds the overflow flag, which software clears by writing a 1 to it. The divider select can be changed only during a short window after reset. After that window the divider setting is frozen, but the interrupt enable can still be written.

There are no data streams, so the block has no valid/ready handshake. Every register access is a single-cycle strobe that completes in the cycle it is presented, and the block never applies back-pressure. Read data is combinational from the registers while the strobe is high.

Top module: `frc_timer`

## Requirements
- R1: After reset the count is 0x0000, the control byte (address 2) reads 0x00 and the status byte (address 3) reads 0x00, so the divider is divide-by-1 and the interrupt is off.
- R2: The divider select is control bits 1:0. Encodings 00, 01, 10 and 11 divide by 1, 4, 8 and 16. A 4-bit phase counter, cleared by reset, advances on every clock. The count advances on a clock edge when the phase bits covered by (divide-1) are all ones.
- R3: The count advances by one on each divided tick, holds otherwise, wraps from 0xFFFF to 0x0000, and is always present on `count_out`.
- R4: A wrap sets the overflow flag (status bit 7). If a wrap and a clear land on the same edge, the flag ends up set.
- R5: Writing status with bit 7 = 1 clears the flag. Writing bit 7 = 0 leaves it unchanged.
- R6: `ovf_irq` is high exactly when the overflow flag and the interrupt enable (control bit 7) are both 1.
- R7: A control write changes the divider select only on one of the first 64 clock edges after reset. Later control writes update the interrupt enable and keep the divider select.
- R8: A read of address 0 returns count bits 15:8 and captures count bits 7:0. The next read of address 1 returns the captured byte and consumes the capture. A read of address 1 with no pending capture returns the live low byte.
- R9: Writes to addresses 0 and 1 change neither the count nor any other state.
- R10: Unused control bits 6:2 and status bits 6:0 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 2 | 0 count high, 1 count low, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read strobe is high, else 0 |
| count_out | output | 16 | Live count for other timer functions |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 2-bit divider select and a 64-cycle lock window. At divide-by-1 the 16-bit width puts the first wrap about 65,536 cycles after reset, which fits in the run. The bench uses that wrap to line up a status clear on the exact wrap edge. The 64-cycle window is short enough that all four divide ratios can be programmed and exercised before the lock closes, and a later write can then show that the select is frozen.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    REG_CNT_HI = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } frc_reg_e;

  localparam int BYTE_W      = 8;
  localparam int CTRL_IE_BIT = 7;
  localparam int STAT_OV_BIT = 7;
endpackage

// File: rtl/frc_lock.sv
module frc_lock #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic open_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cyc_q <= '0;
    else if (cyc_q != CW'(LOCK_CYCLES))
      cyc_q <= cyc_q + 1'b1;
  end

  assign open_o = (cyc_q < CW'(LOCK_CYCLES));
endmodule

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NSEL = 1 << SEL_W;
  localparam int PH_W = NSEL;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask_tab [NSEL];
  logic [PH_W-1:0] sel_mask;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    if (g == 0) begin : g_div1
      assign mask_tab[g] = '0;
    end else begin : g_divn
      assign mask_tab[g] = PH_W'((1 << (g + 1)) - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else
      phase_q <= phase_q + 1'b1;
  end

  assign sel_mask = mask_tab[sel_i];
  assign tick_o   = ((phase_q & sel_mask) == sel_mask);
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (tick_i)
      count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign wrap_o  = tick_i && (count_q == '1);
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PR_W        = 2,
  parameter int LOCK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  count_out,
  output logic              ovf_irq
);
  localparam int HI_W = CNT_W - BYTE_W;

  frc_reg_e         addr;
  logic             rd_req, wr_req;
  logic             tick, wrap, lock_open;
  logic [CNT_W-1:0] count_q;
  logic             toi_q, tof_q;
  logic [PR_W-1:0]  pr_q;
  logic [BYTE_W-1:0] lo_hold_q;
  logic             hold_v_q;
  logic             unused_wdata;

  assign addr   = frc_reg_e'(bus_addr);
  assign rd_req = bus_sel && !bus_wr;
  assign wr_req = bus_sel && bus_wr;

  frc_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_o (lock_open)
  );

  frc_prescaler #(.SEL_W(PR_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (pr_q),
    .tick_o (tick)
  );

  frc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .count_o (count_q),
    .wrap_o  (wrap)
  );

  // control byte: enable always writable, divider select only while open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toi_q <= 1'b0;
      pr_q  <= '0;
    end else if (wr_req && addr == REG_CTRL) begin
      toi_q <= bus_wdata[CTRL_IE_BIT];
      if (lock_open)
        pr_q <= bus_wdata[PR_W-1:0];
    end
  end

  // overflow flag: set on wrap beats a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tof_q <= 1'b0;
    else if (wrap)
      tof_q <= 1'b1;
    else if (wr_req && addr == REG_STAT && bus_wdata[STAT_OV_BIT])
      tof_q <= 1'b0;
  end

  // coherent two-byte read: high byte read captures the low byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold_q <= '0;
      hold_v_q  <= 1'b0;
    end else if (rd_req && addr == REG_CNT_HI) begin
      lo_hold_q <= count_q[BYTE_W-1:0];
      hold_v_q  <= 1'b1;
    end else if (rd_req && addr == REG_CNT_LO) begin
      hold_v_q  <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      unique case (addr)
        REG_CNT_HI: bus_rdata = BYTE_W'(count_q[CNT_W-1 -: HI_W]);
        REG_CNT_LO: bus_rdata = hold_v_q ? lo_hold_q : count_q[BYTE_W-1:0];
        REG_CTRL: begin
          bus_rdata[CTRL_IE_BIT] = toi_q;
          bus_rdata[PR_W-1:0]    = pr_q;
        end
        REG_STAT: bus_rdata[STAT_OV_BIT] = tof_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign unused_wdata = ^bus_wdata;
  assign count_out    = count_q;
  assign ovf_irq      = tof_q && toi_q;
endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PR_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic [PR_W-1:0]  pr,
  input logic             lock_open,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata
);
  logic clr_req;
  assign clr_req = bus_sel && bus_wr && (bus_addr == 2'd3) && bus_wdata[7];

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == CNT_W'($past(count) + 1'b1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (count == $past(count)));

  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '1) |=> flag);

  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(tick && count == '1)) |=> !flag);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);

  a_r7_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_open |=> $stable(pr));

  a_r2_div16_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pr == '1 && tick && !lock_open) |=> !tick);
endmodule

bind frc_timer frc_timer_chk #(.CNT_W(CNT_W), .PR_W(PR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .count     (count_q),
  .flag      (tof_q),
  .pr        (pr_q),
  .lock_open (lock_open),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_frc_timer.sv
module tb_frc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic [15:0] count_out;
  logic        ovf_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frc_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count_out (count_out),
    .ovf_irq   (ovf_irq)
  );

  // reference model built from the requirements
  int          m_k = 0;
  logic [15:0] m_cnt = 16'd0;
  logic [1:0]  m_pr = 2'd0;
  logic        m_toi = 1'b0;
  logic        m_tof = 1'b0;
  logic [7:0]  m_hold = 8'd0;
  logic        m_hv = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    logic [3:0] dm;
    logic       tk;
    logic       wp;
    if (!rst_n) begin
      m_k = 0; m_cnt = 16'd0; m_pr = 2'd0; m_toi = 1'b0;
      m_tof = 1'b0; m_hold = 8'd0; m_hv = 1'b0;
    end else begin
      dm = (m_pr == 2'd0) ? 4'd0 : 4'((1 << (int'(m_pr) + 1)) - 1);
      tk = ((4'(m_k) & dm) == dm);
      wp = tk && (m_cnt == 16'hFFFF);
      if (wp) m_tof = 1'b1;
      else if (bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[7]) m_tof = 1'b0;
      if (bus_sel && bus_wr && bus_addr == 2'd2) begin
        m_toi = bus_wdata[7];
        if (m_k < 64) m_pr = bus_wdata[1:0];
      end
      if (bus_sel && !bus_wr && bus_addr == 2'd0) begin
        m_hold = m_cnt[7:0]; m_hv = 1'b1;
      end else if (bus_sel && !bus_wr && bus_addr == 2'd1) begin
        m_hv = 1'b0;
      end
      if (tk) m_cnt = m_cnt + 16'd1;
      m_k++;
    end
  end

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [7:0] model_read(logic [1:0] a);
    case (a)
      2'd0:    return m_cnt[15:8];
      2'd1:    return m_hv ? m_hold : m_cnt[7:0];
      2'd2:    return {m_toi, 5'd0, m_pr};
      default: return {m_tof, 7'd0};
    endcase
  endfunction

  // monitor: samples 3 ns after the falling edge, well before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        checks++;
        if (count_out !== m_cnt) begin
          errors++;
          $display("FAIL R3 count_out actual %h expected %h", count_out, m_cnt);
        end
        checks++;
        if (ovf_irq !== (m_tof && m_toi)) begin
          errors++;
          $display("FAIL R6 ovf_irq actual %b expected %b", ovf_irq, m_tof && m_toi);
        end
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          checks++;
          if (bus_rdata !== e.exp) begin
            errors++;
            $display("FAIL %s bus_rdata actual %h expected %h", e.tag, bus_rdata, e.exp);
          end
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    sb_q.push_back('{exp: model_read(a), tag: tag});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    // phase 1: reset state, divide ratios, lock, coherent reads
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(2'd2, "R1");
    rd(2'd3, "R1");
    rd(2'd0, "R1");
    wr(2'd2, 8'h01);            // R2 divide by 4
    idle(12);
    wr(2'd2, 8'h02);            // R2 divide by 8
    idle(16);
    wr(2'd2, 8'h03);            // R2 divide by 16
    idle(40);
    wr(2'd2, 8'h80);            // R7 past window: select must stay 11
    rd(2'd2, "R7");
    rd(2'd0, "R8");
    idle(20);
    rd(2'd1, "R8");             // captured byte
    idle(20);
    rd(2'd1, "R8");             // live byte, capture consumed
    wr(2'd0, 8'h55);            // R9 ignored
    wr(2'd1, 8'hAA);            // R9 ignored
    rd(2'd0, "R9");
    rd(2'd1, "R9");

    // phase 2: unused bits, overflow, clear, gating
    do_reset();
    rd(2'd2, "R1");
    wr(2'd2, 8'hFC);            // R10 enable on, select 00, junk bits
    rd(2'd2, "R10");
    wr(2'd3, 8'h7F);            // R10 junk status bits
    rd(2'd3, "R10");
    while (m_cnt != 16'hFFFF) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h80; // R4 clear on wrap edge
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(2'd3, "R4");
    wr(2'd3, 8'h00);            // R5 zero keeps flag
    rd(2'd3, "R5");
    wr(2'd2, 8'h00);            // R6 gate off
    idle(2);
    wr(2'd2, 8'h80);            // R6 gate on
    idle(2);
    wr(2'd3, 8'h80);            // R5 clear
    rd(2'd3, "R5");
    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule